// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block multiplies two signed operands and adds the product to a 64-bit signed accumulator. The accumulator is kept as two 32-bit halves, a high word and a low word, and both halves are driven out of registers. One control input picks between two product forms. The long form multiplies the full 32-bit operands. The word form multiplies only the sign-extended low 16 bits of each operand.

A saturation-enable input follows a processor mode bit. When it is clear, every accumulation wraps modulo 2^64. When it is set, the limit depends on the product form. The long form clamps the result to a signed 48-bit range. The word form clamps the low word to a signed 32-bit range and writes 1 into the high word as a marker. In either form, clamping raises a one-cycle overflow pulse.

Separate strobes clear the accumulator or load either half directly. An accumulate takes one cycle, and its result appears on the outputs after the next rising clock edge.

Top module: `mac_sat_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `acc_hi`, `acc_lo` and `sat_ovf` become zero.
- R2: `acc_clr` zeroes both halves and `sat_ovf` at the next edge. It takes priority over loads and accumulates.
- R3: `ld_hi` writes `ld_hi_val` into the high word, and `ld_lo` writes `ld_lo_val` into the low word, at the next edge. The two strobes are independent, and a half that is not loaded holds its value. While either strobe is high, an accumulate request is ignored.
- R4: With `op_valid` high and `op_word`=0 (long form), the sign-extended signed product of the full 32-bit `op_a` and `op_b` is added to {`acc_hi`,`acc_lo`}.
- R5: With `op_word`=1 (word form), only bits [15:0] of each operand are used, as signed values. Bits [31:16] have no effect on the result.
- R6: In the long form with `sat_en`=1, a sum below -2^47 gives `acc_hi`=0xFFFF8000 and `acc_lo`=0. A sum above 2^47-1 gives `acc_hi`=0x00007FFF and `acc_lo`=0xFFFFFFFF. A sum inside that range is stored unchanged, so bits [31:15] of `acc_hi` are always all ones or all zeros.
- R7: In the word form with `sat_en`=1, a sum below -2^31 gives `acc_lo`=0x80000000, and a sum above 2^31-1 gives `acc_lo`=0x7FFFFFFF. In both of these cases `acc_hi` becomes 1. A sum inside the range is stored as the full 64-bit value.
- R8: With `sat_en`=0, both forms wrap modulo 2^64 and `sat_ovf` stays 0.
- R9: In a cycle with no clear, load or accumulate request, both halves hold their values and `sat_ovf` is 0 after the edge.
- R10: `sat_ovf` is 1 for exactly the one cycle after a saturating accumulate that was clamped. After any other edge it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| acc_clr | input | 1 | Zero the accumulator |
| ld_hi | input | 1 | Load the high word |
| ld_lo | input | 1 | Load the low word |
| ld_hi_val | input | 32 | Value for the high word |
| ld_lo_val | input | 32 | Value for the low word |
| op_valid | input | 1 | Accumulate request |
| op_word | input | 1 | 0 = long form, 1 = word form |
| sat_en | input | 1 | Enable saturation |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| acc_hi | output | 32 | Accumulator high word |
| acc_lo | output | 32 | Accumulator low word |
| sat_ovf | output | 1 | Clamp indication pulse |

## Verification
The assertions assume that the controls are sampled at every rising edge and follow a fixed priority: reset first, then clear, then load, then accumulate. The range check for the long form and the marker check for the word form apply only to an accumulate that no clear or load overrides. The stimulus changes inputs only on falling edges. Before each table vector it preloads the accumulator with a separate load cycle, so every accumulate starts from a known value. Strobes that overlap on purpose are limited to the directed priority tests.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic {
    MODE_LONG = 1'b0,
    MODE_WORD = 1'b1
  } mac_mode_e;
endpackage

// File: rtl/mac_product.sv
module mac_product
  import mac_pkg::*;
#(
  parameter int OPW = 32,
  parameter int SHW = 16
) (
  input  mac_mode_e          mode,
  input  logic [OPW-1:0]     a,
  input  logic [OPW-1:0]     b,
  output logic [2*OPW-1:0]   prod
);
  localparam int PW = 2 * OPW;
  localparam int SPW = 2 * SHW;

  logic signed [PW-1:0]  p_long;
  logic signed [SPW-1:0] p_short;
  logic        [PW-1:0]  p_word;

  assign p_long  = $signed({{OPW{a[OPW-1]}}, a}) * $signed({{OPW{b[OPW-1]}}, b});
  assign p_short = $signed(a[SHW-1:0]) * $signed(b[SHW-1:0]);
  assign p_word  = {{(PW-SPW){p_short[SPW-1]}}, p_short};

  always_comb begin
    if (mode == MODE_WORD) prod = p_word;
    else                   prod = p_long;
  end
endmodule

// File: rtl/mac_sat_stage.sv
module mac_sat_stage
  import mac_pkg::*;
#(
  parameter int ACCW  = 64,
  parameter int LSATW = 48,
  parameter int WSATW = 32
) (
  input  mac_mode_e        mode,
  input  logic             sat_en,
  input  logic [ACCW-1:0]  acc,
  input  logic [ACCW-1:0]  prod,
  output logic [ACCW-1:0]  res,
  output logic             ovf
);
  localparam int HALF = ACCW / 2;
  localparam int SW   = ACCW + 1;
  localparam logic signed [SW-1:0] L_MAX = {{(SW-LSATW+1){1'b0}}, {(LSATW-1){1'b1}}};
  localparam logic signed [SW-1:0] L_MIN = {{(SW-LSATW+1){1'b1}}, {(LSATW-1){1'b0}}};
  localparam logic signed [SW-1:0] W_MAX = {{(SW-WSATW+1){1'b0}}, {(WSATW-1){1'b1}}};
  localparam logic signed [SW-1:0] W_MIN = {{(SW-WSATW+1){1'b1}}, {(WSATW-1){1'b0}}};
  localparam logic [HALF-1:0] MARK = HALF'(1);

  logic signed [SW-1:0] sum;
  logic hi_over, lo_under;

  assign sum = $signed({acc[ACCW-1], acc}) + $signed({prod[ACCW-1], prod});

  always_comb begin
    if (mode == MODE_WORD) begin
      hi_over  = sum > W_MAX;
      lo_under = sum < W_MIN;
    end else begin
      hi_over  = sum > L_MAX;
      lo_under = sum < L_MIN;
    end
  end

  always_comb begin
    res = sum[ACCW-1:0];
    ovf = 1'b0;
    if (sat_en && (hi_over || lo_under)) begin
      ovf = 1'b1;
      if (mode == MODE_WORD)
        res = {MARK, hi_over ? W_MAX[HALF-1:0] : W_MIN[HALF-1:0]};
      else
        res = hi_over ? L_MAX[ACCW-1:0] : L_MIN[ACCW-1:0];
    end
  end
endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
  import mac_pkg::*;
#(
  parameter int HALF  = 32,
  parameter int SHW   = 16,
  parameter int LSATW = 48
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            acc_clr,
  input  logic            ld_hi,
  input  logic            ld_lo,
  input  logic [HALF-1:0] ld_hi_val,
  input  logic [HALF-1:0] ld_lo_val,
  input  logic            op_valid,
  input  logic            op_word,
  input  logic            sat_en,
  input  logic [HALF-1:0] op_a,
  input  logic [HALF-1:0] op_b,
  output logic [HALF-1:0] acc_hi,
  output logic [HALF-1:0] acc_lo,
  output logic            sat_ovf
);
  localparam int ACCW = 2 * HALF;
  localparam int TOPB = LSATW - 1 - HALF;
  localparam logic [HALF-1:0] W_POS = {1'b0, {(HALF-1){1'b1}}};
  localparam logic [HALF-1:0] W_NEG = {1'b1, {(HALF-1){1'b0}}};

  mac_mode_e       mode;
  logic [ACCW-1:0] prod, nxt;
  logic            nxt_ovf, any_ld, do_op;

  assign mode   = op_word ? MODE_WORD : MODE_LONG;
  assign any_ld = ld_hi | ld_lo;
  assign do_op  = op_valid & ~acc_clr & ~any_ld;

  mac_product #(.OPW(HALF), .SHW(SHW)) u_prod (
    .mode(mode), .a(op_a), .b(op_b), .prod(prod)
  );

  mac_sat_stage #(.ACCW(ACCW), .LSATW(LSATW), .WSATW(HALF)) u_sat (
    .mode(mode), .sat_en(sat_en), .acc({acc_hi, acc_lo}), .prod(prod),
    .res(nxt), .ovf(nxt_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst || acc_clr) begin
      acc_hi  <= '0;
      acc_lo  <= '0;
      sat_ovf <= 1'b0;
    end else if (any_ld) begin
      if (ld_hi) acc_hi <= ld_hi_val;
      if (ld_lo) acc_lo <= ld_lo_val;
      sat_ovf <= 1'b0;
    end else if (op_valid) begin
      {acc_hi, acc_lo} <= nxt;
      sat_ovf          <= nxt_ovf;
    end else begin
      sat_ovf <= 1'b0;
    end
  end

  // Clear wins over everything below it
  p_clear_zero_r2: assert property (@(posedge clk) disable iff (rst)
    acc_clr |=> (acc_hi == '0 && acc_lo == '0 && !sat_ovf));

  p_load_hi_r3: assert property (@(posedge clk) disable iff (rst)
    (ld_hi && !acc_clr) |=> acc_hi == $past(ld_hi_val));

  p_load_lo_r3: assert property (@(posedge clk) disable iff (rst)
    (ld_lo && !acc_clr) |=> acc_lo == $past(ld_lo_val));

  p_long_range_r6: assert property (@(posedge clk) disable iff (rst)
    (do_op && !op_word && sat_en) |=>
      (acc_hi[HALF-1:TOPB] == '0 || acc_hi[HALF-1:TOPB] == '1));

  p_word_marker_r7: assert property (@(posedge clk) disable iff (rst)
    (do_op && op_word && sat_en) |=>
      (!sat_ovf || (acc_hi == HALF'(1) && (acc_lo == W_POS || acc_lo == W_NEG))));

  p_no_ovf_r8: assert property (@(posedge clk) disable iff (rst)
    (!do_op || !sat_en) |=> !sat_ovf);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && !acc_clr && !any_ld) |=> ($stable(acc_hi) && $stable(acc_lo)));

  p_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    (sat_ovf && !op_valid) |=> !sat_ovf);

  always_comb begin
    if (!rst) a_ovf_mode_r10: assert (nxt_ovf == 1'b0 || sat_en);
  end
endmodule

// File: tb/tb_mac_sat_unit.sv
`timescale 1ns/1ps
module tb_mac_sat_unit;
  logic        clk = 1'b0;
  logic        rst, acc_clr, ld_hi, ld_lo, op_valid, op_word, sat_en;
  logic [31:0] ld_hi_val, ld_lo_val, op_a, op_b, acc_hi, acc_lo;
  logic        sat_ovf;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mac_sat_unit dut (
    .clk(clk), .rst(rst), .acc_clr(acc_clr), .ld_hi(ld_hi), .ld_lo(ld_lo),
    .ld_hi_val(ld_hi_val), .ld_lo_val(ld_lo_val), .op_valid(op_valid),
    .op_word(op_word), .sat_en(sat_en), .op_a(op_a), .op_b(op_b),
    .acc_hi(acc_hi), .acc_lo(acc_lo), .sat_ovf(sat_ovf)
  );

  typedef struct packed {
    logic        word;
    logic        sat;
    logic [31:0] pre_hi;
    logic [31:0] pre_lo;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] exp_hi;
    logic [31:0] exp_lo;
    logic        exp_ovf;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 32'h0, 32'h0, 32'd3, 32'd5, 32'h0, 32'd15, 1'b0},
    '{1'b0, 1'b0, 32'h0, 32'h0, 32'hFFFFFFFE, 32'd7, 32'hFFFFFFFF, 32'hFFFFFFF2, 1'b0},
    '{1'b0, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd1, 32'd1, 32'h0, 32'h0, 1'b0},
    '{1'b0, 1'b0, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'd1, 32'd1, 32'h80000000, 32'h0, 1'b0},
    '{1'b1, 1'b0, 32'h0, 32'h0, 32'h1234FFFF, 32'hABCD0003, 32'hFFFFFFFF, 32'hFFFFFFFD, 1'b0},
    '{1'b0, 1'b1, 32'h00007FFF, 32'hFFFFFFF0, 32'h10, 32'd1, 32'h00007FFF, 32'hFFFFFFFF, 1'b1},
    '{1'b0, 1'b1, 32'hFFFF8000, 32'h0, 32'hFFFFFFFF, 32'd1, 32'hFFFF8000, 32'h0, 1'b1},
    '{1'b0, 1'b1, 32'h00007FFF, 32'hFFFFFFF0, 32'hF, 32'd1, 32'h00007FFF, 32'hFFFFFFFF, 1'b0},
    '{1'b1, 1'b1, 32'h0, 32'h7FFFFFFF, 32'd1, 32'd1, 32'h1, 32'h7FFFFFFF, 1'b1},
    '{1'b1, 1'b1, 32'hFFFFFFFF, 32'h80000000, 32'h0000FFFF, 32'd1, 32'h1, 32'h80000000, 1'b1},
    '{1'b1, 1'b1, 32'h0, 32'h0, 32'h00008000, 32'h00008000, 32'h0, 32'h40000000, 1'b0},
    '{1'b0, 1'b0, 32'h0, 32'h0, 32'h80000000, 32'h80000000, 32'h40000000, 32'h0, 1'b0},
    '{1'b0, 1'b1, 32'h0, 32'h0, 32'h80000000, 32'h80000000, 32'h00007FFF, 32'hFFFFFFFF, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] eh, input logic [31:0] el,
                       input logic eo);
    checks++;
    if (acc_hi !== eh || acc_lo !== el || sat_ovf !== eo) begin
      errors++;
      $display("FAIL %s: actual hi=%h lo=%h ovf=%b expected hi=%h lo=%h ovf=%b",
               req, acc_hi, acc_lo, sat_ovf, eh, el, eo);
    end
  endtask

  task automatic idle();
    acc_clr = 0; ld_hi = 0; ld_lo = 0; op_valid = 0;
  endtask

  task automatic preload(input logic [31:0] h, input logic [31:0] l);
    @(negedge clk);
    idle();
    ld_hi = 1; ld_lo = 1; ld_hi_val = h; ld_lo_val = l;
    @(negedge clk);
    idle();
  endtask

  task automatic do_op(input logic w, input logic s, input logic [31:0] a,
                       input logic [31:0] b);
    idle();
    op_valid = 1; op_word = w; sat_en = s; op_a = a; op_b = b;
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; idle(); op_word = 0; sat_en = 0;
    ld_hi_val = 0; ld_lo_val = 0; op_a = 0; op_b = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 reset", 32'h0, 32'h0, 1'b0);

    // Table walk: R4 R5 R6 R7 R8 R10
    for (int i = 0; i < NV; i++) begin
      preload(VEC[i].pre_hi, VEC[i].pre_lo);
      do_op(VEC[i].word, VEC[i].sat, VEC[i].a, VEC[i].b);
      check($sformatf("R4/R5/R6/R7/R8 vector %0d", i),
            VEC[i].exp_hi, VEC[i].exp_lo, VEC[i].exp_ovf);
    end

    // R10: pulse drops after one idle cycle, R9 values hold
    preload(32'h0, 32'h7FFFFFFF);
    do_op(1'b1, 1'b1, 32'd2, 32'd2);
    check("R10 pulse high", 32'h1, 32'h7FFFFFFF, 1'b1);
    @(negedge clk);
    check("R10 pulse one cycle", 32'h1, 32'h7FFFFFFF, 1'b0);
    repeat (3) @(negedge clk);
    check("R9 hold idle", 32'h1, 32'h7FFFFFFF, 1'b0);

    // R4: back-to-back accumulation
    preload(32'h0, 32'h0);
    do_op(1'b0, 1'b0, 32'd3, 32'd5);
    do_op(1'b0, 1'b0, 32'd2, 32'd2);
    check("R4 back-to-back", 32'h0, 32'd19, 1'b0);

    // R5: upper operand bits ignored in word form
    preload(32'h0, 32'h0);
    do_op(1'b1, 1'b0, 32'hFFFF0004, 32'h7FFF0005);
    check("R5 upper bits ignored", 32'h0, 32'd20, 1'b0);

    // R3: load high only while op requested; op ignored, low held
    preload(32'h0, 32'h55);
    ld_hi = 1; ld_hi_val = 32'hCAFE0001; op_valid = 1; op_word = 0;
    sat_en = 0; op_a = 32'd9; op_b = 32'd9;
    @(negedge clk); idle();
    check("R3 load hi over op", 32'hCAFE0001, 32'h55, 1'b0);
    ld_lo = 1; ld_lo_val = 32'h12345678;
    @(negedge clk); idle();
    check("R3 load lo only", 32'hCAFE0001, 32'h12345678, 1'b0);

    // R2: clear beats load and op
    acc_clr = 1; ld_hi = 1; ld_lo = 1; ld_hi_val = 32'h1; ld_lo_val = 32'h1;
    op_valid = 1;
    @(negedge clk); idle();
    check("R2 clear priority", 32'h0, 32'h0, 1'b0);

    // R8: saturation off never flags, wraps at 2^64
    preload(32'hFFFFFFFF, 32'hFFFFFFFF);
    do_op(1'b1, 1'b0, 32'd1, 32'd2);
    check("R8 wrap word", 32'h0, 32'h1, 1'b0);

    // R1: reset mid-run
    preload(32'h11, 32'h22);
    rst = 1;
    @(negedge clk);
    rst = 0;
    check("R1 reset mid-run", 32'h0, 32'h0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule